// File: doc/BRIEF.md
# Write-Armed Overflow Interrupt Timer

This block is a 16-bit up-counter that advances once per CPU-cycle strobe and raises a level interrupt when it rolls over from all ones to zero. Software sets the starting value with two byte writes, low then high. The high-byte write also starts counting. A third register stops the counter, zeroes it and withdraws the interrupt in a single write.

All three registers sit in the upper half of the address space, where address bit 15 is 1. Address bits [3:0] pick the register. Writes anywhere else leave the block untouched. A small state machine tracks two flags: whether the counter is armed, and whether an interrupt is pending.

Its states are:
- ST_IDLE: disarmed, nothing pending.
- ST_ARMED: counting, nothing pending.
- ST_FIRED: disarmed, pending.
- ST_FIRED_ARMED: counting, still pending.

Its transitions are:
- ARM: a high-byte write while not pending, which moves to ST_ARMED.
- REARM: a high-byte write while pending, which moves to ST_FIRED_ARMED.
- WRAP: a rollover while counting, which moves to ST_FIRED.
- ACK: an acknowledge write from any state, which moves to ST_IDLE.

Top module: `irq_upcounter`

## Requirements
- R1: A write with address bit 15 = 1 and address bits [3:0] = 0xE loads the data byte into counter bits [7:0] and leaves bits [15:8] unchanged.
- R2: A write with address bit 15 = 1 and address bits [3:0] = 0xF loads the data byte into counter bits [15:8] and arms the counter.
- R3: A write with address bit 15 = 1 and address bits [3:0] = 0xD zeroes the counter, disarms it and clears the pending interrupt.
- R4: While armed, each clock with `cpu_tick` high adds one to the counter, modulo 2^16. While disarmed, the counter holds.
- R5: An increment that rolls the counter to 0x0000 sets the pending flag and disarms the counter on the same clock edge. Further ticks leave the counter at 0.
- R6: Once set, the pending flag stays set until an acknowledge write (R3). This includes the case where the counter is re-armed with a high-byte write.
- R7: After loading 0xFFFF, a single tick raises `irq` right after that clock edge.
- R8: After reset, `count_dbg` is 0, the counter is disarmed and `irq` is low.
- R9: `irq` is active-high and equals the pending flag, with no pulse shaping.
- R10: If a write to any of the three registers and a tick fall in the same clock, the write takes effect and no increment happens in that clock.
- R11: Writes with address bit 15 = 0, or with address bits [3:0] outside 0xD..0xF, change nothing and do not block that clock's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One-clock strobe per CPU cycle |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| irq | output | 1 | Level interrupt request, active-high |
| count_dbg | output | 16 | Current counter value |

## Verification
The main sweep tries every low-byte start value with the high byte at 0xFF. It counts the ticks until `irq` rises and compares that count with 256 minus the start value, which catches off-by-one errors and lost carries in the low byte. A second sweep sets the low byte to zero and steps the high byte from 0xF8 to 0xFF, so the carry into the upper byte is exercised too. Directed patterns cover the rest:
- ticks arriving together with register writes, which separates write priority from increment;
- writes outside the register window, which separate decode from state change;
- re-arming while an interrupt is pending, which separates the pending flag from the armed flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ARMED       = 2'd1,
        ST_FIRED       = 2'd2,
        ST_FIRED_ARMED = 2'd3
    } irqc_state_e;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_ACK  = 4'hD;
    localparam logic [SEL_W-1:0] SEL_LOAD_LO = 4'hE;
    localparam logic [SEL_W-1:0] SEL_LOAD_HI = 4'hF;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic              ack
);
    import irqc_pkg::*;

    logic             in_window;
    logic [SEL_W-1:0] sel;
    logic             unused_addr_bits;

    assign in_window        = wr_en && wr_addr[ADDR_W-1];
    assign sel              = wr_addr[SEL_W-1:0];
    assign unused_addr_bits = ^wr_addr[ADDR_W-2:SEL_W];

    always_comb begin
        ld_lo = 1'b0;
        ld_hi = 1'b0;
        ack   = 1'b0;
        if (in_window) begin
            unique case (sel)
                SEL_LOAD_LO: ld_lo = 1'b1;
                SEL_LOAD_HI: ld_hi = 1'b1;
                SEL_ACK:     ack   = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_count.sv
module irqc_count #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic                inc,
    input  logic [DATA_W-1:0]   data,
    output logic [2*DATA_W-1:0] count,
    output logic                wrap
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ld_lo) begin
            cnt_q[DATA_W-1:0] <= data;
        end else if (ld_hi) begin
            cnt_q[CNT_W-1:DATA_W] <= data;
        end else if (inc) begin
            cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign count = cnt_q;
    assign wrap  = inc && (&cnt_q);
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic arm,
    input  logic wrap,
    output logic armed,
    output logic pending
);
    import irqc_pkg::*;

    irqc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ack) begin
            state_d = ST_IDLE;
        end else if (arm) begin
            unique case (state_q)
                ST_IDLE, ST_ARMED:        state_d = ST_ARMED;
                ST_FIRED, ST_FIRED_ARMED: state_d = ST_FIRED_ARMED;
                default:                  state_d = ST_IDLE;
            endcase
        end else if (wrap) begin
            state_d = ST_FIRED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:        begin armed = 1'b0; pending = 1'b0; end
            ST_ARMED:       begin armed = 1'b1; pending = 1'b0; end
            ST_FIRED:       begin armed = 1'b0; pending = 1'b1; end
            ST_FIRED_ARMED: begin armed = 1'b1; pending = 1'b1; end
            default:        begin armed = 1'b0; pending = 1'b0; end
        endcase
    end
endmodule

// File: rtl/irq_upcounter.sv
module irq_upcounter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic [CNT_W-1:0]  count_dbg
);
    logic ld_lo, ld_hi, ack;
    logic armed, pending, inc, wrap;

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ack     (ack)
    );

    // Register writes take priority over a tick in the same clock.
    assign inc = cpu_tick && armed && !(ld_lo || ld_hi || ack);

    irqc_count #(.DATA_W(DATA_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ack),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .inc   (inc),
        .data  (wr_data),
        .count (count_dbg),
        .wrap  (wrap)
    );

    irqc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .arm     (ld_hi),
        .wrap    (wrap),
        .armed   (armed),
        .pending (pending)
    );

    assign irq = pending;
endmodule

// File: rtl/irq_upcounter_checker.sv
module irq_upcounter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_tick,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        irq,
    input logic [15:0] count_dbg
);
    logic hit_lo, hit_hi, hit_ack, hit_any;
    assign hit_lo  = wr_en && wr_addr[15] && (wr_addr[3:0] == 4'hE);
    assign hit_hi  = wr_en && wr_addr[15] && (wr_addr[3:0] == 4'hF);
    assign hit_ack = wr_en && wr_addr[15] && (wr_addr[3:0] == 4'hD);
    assign hit_any = hit_lo || hit_hi || hit_ack;

    p_lo_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> (count_dbg[7:0] == $past(wr_data)) &&
                   (count_dbg[15:8] == $past(count_dbg[15:8])));

    p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_hi |=> (count_dbg[15:8] == $past(wr_data)) &&
                   (count_dbg[7:0] == $past(count_dbg[7:0])));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ack |=> (count_dbg == 16'h0000) && !irq);

    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |=> (count_dbg == $past(count_dbg)) ||
                     (count_dbg == $past(count_dbg) + 16'd1));

    p_rise_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (count_dbg == 16'h0000) && ($past(count_dbg) == 16'hFFFF));

    p_disarm_after_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && cpu_tick && !hit_any) |=> (count_dbg == 16'h0000));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !hit_ack) |=> irq);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo && cpu_tick) |=> (count_dbg[15:8] == $past(count_dbg[15:8])));
endmodule

bind irq_upcounter irq_upcounter_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_tick  (cpu_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .count_dbg (count_dbg)
);

// File: tb/irq_upcounter_tb_top.sv
`timescale 1ns/1ps
module irq_upcounter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;
    logic [15:0] count_dbg;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_upcounter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_tick  (cpu_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq       (irq),
        .count_dbg (count_dbg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-clock write; tick may be driven in the same clock.
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic t = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cpu_tick = t;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cpu_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_tick = 1'b1;
            @(posedge clk);
        end
        @(negedge clk); cpu_tick = 1'b0;
    endtask

    // Tick until irq rises; returns the number of ticks used.
    task automatic run_to_irq(output int n);
        n = 0;
        @(negedge clk);
        while (!irq && n < 70000) begin
            cpu_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        cpu_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 count", count_dbg, 16'h0000);
        check("R8 irq", irq, 1'b0);
        rst_n = 1'b1;
        ticks(4);
        check("R8 disarmed", count_dbg, 16'h0000);

        wr(16'h800E, 8'h5A);
        check("R1 lo load", count_dbg, 16'h005A);
        ticks(3);
        check("R4 hold when disarmed", count_dbg, 16'h005A);
        wr(16'h800F, 8'h12);
        check("R2 hi load", count_dbg, 16'h125A);
        ticks(3);
        check("R4 increment", count_dbg, 16'h125D);

        wr(16'h800E, 8'h00, 1'b1);
        check("R10 write wins", count_dbg, 16'h1200);
        ticks(1);
        check("R10 resume", count_dbg, 16'h1201);

        wr(16'h000E, 8'h77, 1'b1);
        check("R11 low half ignored", count_dbg, 16'h1202);
        wr(16'h8008, 8'h77, 1'b1);
        check("R11 other sel ignored", count_dbg, 16'h1203);
        check("R11 no irq", irq, 1'b0);

        wr(16'h800E, 8'hFF);
        wr(16'h800F, 8'hFF);
        check("R7 loaded", count_dbg, 16'hFFFF);
        check("R9 irq low before wrap", irq, 1'b0);
        ticks(1);
        check("R7 irq after one tick", irq, 1'b1);
        check("R5 count zero", count_dbg, 16'h0000);
        ticks(5);
        check("R6 irq sticky", irq, 1'b1);
        check("R5 disarmed", count_dbg, 16'h0000);

        wr(16'h800E, 8'hFE);
        wr(16'h800F, 8'hFF);
        check("R6 pending across rearm", irq, 1'b1);
        ticks(1);
        check("R4 rearmed counts", count_dbg, 16'hFFFF);
        ticks(3);
        check("R5 second wrap stops", count_dbg, 16'h0000);
        check("R6 still pending", irq, 1'b1);

        wr(16'h800D, 8'h00);
        check("R3 ack irq", irq, 1'b0);
        check("R3 ack count", count_dbg, 16'h0000);

        wr(16'h800F, 8'h40);
        ticks(7);
        check("R4 armed count", count_dbg, 16'h4007);
        wr(16'h800D, 8'h00, 1'b1);
        check("R3 ack mid count", count_dbg, 16'h0000);
        ticks(4);
        check("R3 disarmed by ack", count_dbg, 16'h0000);

        for (int lo = 0; lo < 256; lo++) begin
            wr(16'h800D, 8'h00);
            wr(16'h800E, lo[7:0]);
            wr(16'h800F, 8'hFF);
            run_to_irq(n);
            check("R5 lo sweep ticks", n, 256 - lo);
            check("R5 lo sweep count", count_dbg, 16'h0000);
        end

        for (int hi = 8'hF8; hi < 256; hi++) begin
            wr(16'h800D, 8'h00);
            wr(16'h800E, 8'h00);
            wr(16'h800F, hi[7:0]);
            run_to_irq(n);
            check("R4 hi sweep ticks", n, (256 - hi) * 256);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule